// File: doc/BRIEF.md
# Two-Target Multiplexed-Address CAM Bus Master

This block performs single-byte read and write cycles on a shared 8-bit parallel bus that connects two common-interface controller chips. Each cycle sends the 16-bit address over the data lines in two byte phases. Each byte is captured by its own latch strobe on the target side. After the address, the block drives the write byte or releases the lines for a read. It then asserts the chip select of the addressed target, asserts the read or write strobe, and waits for the target's active-low acknowledge. A bounded timeout limits the wait, so a cycle with no acknowledge still ends.

Two requesters share the bus through a round-robin arbiter. A requester raises its valid line and holds its fields stable until it receives a one-cycle done pulse. The done pulse carries the read byte and a timeout flag. The timeout length is computed from the clock frequency and a microsecond count. Every address and data phase lasts a parameterised number of cycles, which gives setup and hold margin at the external latches.

Top module: `cam_bus_master`

## Requirements
- R1: After reset and whenever no cycle is in progress, `cs_n` = 2'b11, `rd_n` = 1, `wr_n` = 1, `alo_stb` = 0, `ahi_stb` = 0, `bus_oe` = 0 and `cp_done` = 2'b00.
- R2: A cycle begins on the clock after its grant. For PHASE_CYC cycles the block drives address bits [7:0] on `bus_dout` with `bus_oe` = 1 and `alo_stb` = 1. For the next PHASE_CYC cycles it keeps the same byte with `alo_stb` = 0.
- R3: For the next PHASE_CYC cycles the block drives address bits [15:8] with `ahi_stb` = 1. For the PHASE_CYC cycles after that it keeps the same byte with `ahi_stb` = 0. The two latch strobes are never high together.
- R4: Next comes a data phase of PHASE_CYC cycles, with chip selects and read/write strobes inactive. A write (`rq_write` = 1) drives its byte with `bus_oe` = 1. A read (`rq_write` = 0) holds `bus_oe` = 0, and `bus_oe` stays 0 while `rd_n` is low.
- R5: Target 0 uses `cs_n[0]` and target 1 uses `cs_n[1]`. The block pulls only that bit low for PHASE_CYC cycles, then also pulls `rd_n` (read) or `wr_n` (write) low, keeping the data-line state of R4.
- R6: If `ack_n` is sampled low at a rising edge while the strobe is low, the next cycle carries `cp_done[owner]` = 1 for exactly one cycle. In that cycle `cp_rdata` equals `bus_din` as sampled at that edge, and `cp_timeout` = 0.
- R7: If the strobe stays low for TIMEOUT_CYC = (CLK_HZ/1,000,000) × TIMEOUT_US cycles with no acknowledge, the cycle ends as in R6 but with `cp_timeout` = 1. An acknowledge sampled on that last edge takes precedence and gives `cp_timeout` = 0.
- R8: In the done cycle, `cs_n` = 2'b11, `rd_n` = `wr_n` = 1 and `bus_oe` = 0. The cycle after it is idle, and a new grant can occur at the end of that idle cycle.
- R9: When idle, a single valid requester is granted. When both are valid, the one not granted last wins. After reset, requester 0 counts as not granted last.
- R10: Once granted, a cycle follows its owner's request to completion regardless of the other requester's valid line. Only the owner's done bit pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid | input | 2 | Per-requester request valid, held until done |
| rq_write | input | 2 | Per-requester direction, 1 = write |
| rq_addr | input | 32 | Per-requester 16-bit address, requester i in bits [16i+15:16i] |
| rq_wdata | input | 16 | Per-requester write byte, requester i in bits [8i+7:8i] |
| rq_target | input | 2 | Per-requester target chip select index |
| cp_done | output | 2 | One-cycle completion pulse to the owning requester |
| cp_rdata | output | 8 | Byte sampled from the bus at cycle end |
| cp_timeout | output | 1 | High with done when the cycle ended by timeout |
| bus_dout | output | 8 | Data lines driven value |
| bus_oe | output | 1 | Data lines output enable |
| bus_din | input | 8 | Data lines received value |
| alo_stb | output | 1 | Low address byte latch strobe, active high |
| ahi_stb | output | 1 | High address byte latch strobe, active high |
| cs_n | output | 2 | Active-low chip selects, one per target |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from the targets |

## Verification
Acknowledge arrival and timeout expiry can occur on the same rising edge: the last cycle of the strobe window is also the first cycle in which a late acknowledge can be seen. The bench provokes this by setting its responder to pull `ack_n` low exactly TIMEOUT_CYC strobe cycles after the strobe falls. It judges the result by requiring the done pulse with `cp_timeout` = 0 and the responder's byte on `cp_rdata`. Neighbouring runs, where the acknowledge is one cycle too late or never comes, must produce `cp_timeout` = 1 after the full window.

// File: rtl/cam_bus_pkg.sv
// Package: shared widths, phase encoding and request record for the CAM bus master.
package cam_bus_pkg;

    localparam int CAM_DW = 8;
    localparam int CAM_AW = 2 * CAM_DW;

    // Bus cycle phases in the order the sequencer walks them.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ALO_ON,
        PH_ALO_HOLD,
        PH_AHI_ON,
        PH_AHI_HOLD,
        PH_DATA,
        PH_SELECT,
        PH_STROBE,
        PH_RELEASE
    } cam_phase_e;

    // One requester's transfer description.
    typedef struct packed {
        logic              write;
        logic [CAM_AW-1:0] addr;
        logic [CAM_DW-1:0] wdata;
        logic              target;
    } cam_req_t;

endpackage

// File: rtl/cam_bus_arbiter.sv
// Module: two-port round-robin arbiter.
// Grants when the sequencer accepts. If both ports request, the port not
// granted most recently wins. Assumes requests stay high until served.
module cam_bus_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    input  logic       accept,
    output logic       grant,
    output logic       grant_idx
);

    logic last_q;

    // Pick the winner of this cycle.
    always_comb begin
        if (req == 2'b11) begin
            grant_idx = ~last_q;
        end else begin
            grant_idx = req[1];
        end
        grant = accept & (|req);
    end

    // Remember the most recent grant; after reset port 0 goes first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else if (grant) begin
            last_q <= grant_idx;
        end
    end

endmodule

// File: rtl/cam_bus_ack_timer.sv
// Module: acknowledge wait timer.
// Counts cycles while run is high and flags the last allowed cycle.
// Assumes LIMIT >= 1; the count clears whenever run is low.
module cam_bus_ack_timer #(
    parameter int LIMIT = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    // Count strobe cycles, holding at the final value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry is seen on the edge that closes the last allowed cycle.
    always_comb begin
        expired = run && (cnt_q == LAST);
    end

endmodule

// File: rtl/cam_bus_sequencer.sv
// Module: bus cycle sequencer.
// Walks the address, data, select and strobe phases of one transfer. Each
// fixed phase lasts PHASE_CYC cycles. The strobe phase ends on acknowledge
// or timer expiry, and acknowledge wins when both occur together.
// Assumes start is only asserted while the phase is idle.
module cam_bus_sequencer
    import cam_bus_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cam_req_t          start_req,
    input  logic              start_owner,
    input  logic              ack_n,
    input  logic [CAM_DW-1:0] bus_din,
    input  logic              expired,
    output cam_phase_e        phase,
    output cam_req_t          req_q,
    output logic              owner_q,
    output logic              timeout_q,
    output logic [CAM_DW-1:0] rdata_q
);

    localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC + 1) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PHASE_CYC - 1);

    logic [PW-1:0] pcnt_q;
    logic          phase_last;

    // Successor of a fixed-length phase.
    function automatic cam_phase_e next_fixed(input cam_phase_e ph);
        case (ph)
            PH_ALO_ON:   return PH_ALO_HOLD;
            PH_ALO_HOLD: return PH_AHI_ON;
            PH_AHI_ON:   return PH_AHI_HOLD;
            PH_AHI_HOLD: return PH_DATA;
            PH_DATA:     return PH_SELECT;
            default:     return PH_STROBE;
        endcase
    endfunction

    // Detect the final cycle of a fixed phase.
    always_comb begin
        phase_last = (pcnt_q == PLAST);
    end

    // Phase register, request capture and cycle result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            pcnt_q    <= '0;
            req_q     <= '0;
            owner_q   <= 1'b0;
            timeout_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_ALO_ON;
                        req_q   <= start_req;
                        owner_q <= start_owner;
                        pcnt_q  <= '0;
                    end
                end
                PH_ALO_ON, PH_ALO_HOLD, PH_AHI_ON,
                PH_AHI_HOLD, PH_DATA, PH_SELECT: begin
                    if (phase_last) begin
                        pcnt_q <= '0;
                        phase  <= next_fixed(phase);
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (!ack_n) begin
                        phase     <= PH_RELEASE;
                        timeout_q <= 1'b0;
                        rdata_q   <= bus_din;
                    end else if (expired) begin
                        phase     <= PH_RELEASE;
                        timeout_q <= 1'b1;
                        rdata_q   <= bus_din;
                    end
                end
                PH_RELEASE: begin
                    phase <= PH_IDLE;
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/cam_bus_pin_drive.sv
// Module: bus pin decoder.
// Turns the current phase and captured request into data, latch, select,
// strobe and completion outputs. Purely combinational; outputs follow the
// registered phase, so they carry no glitch-prone input paths.
module cam_bus_pin_drive
    import cam_bus_pkg::*;
(
    input  cam_phase_e        phase,
    input  cam_req_t          req_q,
    input  logic              owner_q,
    input  logic              timeout_q,
    output logic [CAM_DW-1:0] bus_dout,
    output logic              bus_oe,
    output logic              alo_stb,
    output logic              ahi_stb,
    output logic [1:0]        cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [1:0]        cp_done,
    output logic              cp_timeout
);

    logic data_stage;
    logic select_stage;

    // Group phases that share data-line and select behaviour.
    always_comb begin
        data_stage   = (phase == PH_DATA) || (phase == PH_SELECT) || (phase == PH_STROBE);
        select_stage = (phase == PH_SELECT) || (phase == PH_STROBE);
    end

    // Decode every bus and completion pin from the phase.
    always_comb begin
        bus_dout   = '0;
        bus_oe     = 1'b0;
        alo_stb    = 1'b0;
        ahi_stb    = 1'b0;
        cs_n       = 2'b11;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        cp_done    = 2'b00;
        cp_timeout = 1'b0;

        case (phase)
            PH_ALO_ON: begin
                bus_dout = req_q.addr[CAM_DW-1:0];
                bus_oe   = 1'b1;
                alo_stb  = 1'b1;
            end
            PH_ALO_HOLD: begin
                bus_dout = req_q.addr[CAM_DW-1:0];
                bus_oe   = 1'b1;
            end
            PH_AHI_ON: begin
                bus_dout = req_q.addr[CAM_AW-1:CAM_DW];
                bus_oe   = 1'b1;
                ahi_stb  = 1'b1;
            end
            PH_AHI_HOLD: begin
                bus_dout = req_q.addr[CAM_AW-1:CAM_DW];
                bus_oe   = 1'b1;
            end
            PH_RELEASE: begin
                cp_done[owner_q] = 1'b1;
                cp_timeout       = timeout_q;
            end
            default: begin
            end
        endcase

        if (data_stage && req_q.write) begin
            bus_dout = req_q.wdata;
            bus_oe   = 1'b1;
        end
        if (select_stage) begin
            cs_n[req_q.target] = 1'b0;
        end
        if (phase == PH_STROBE) begin
            rd_n = req_q.write;
            wr_n = ~req_q.write;
        end
    end

endmodule

// File: rtl/cam_bus_master.sv
// Module: two-requester CAM bus master (top).
// Arbitrates two requesters onto one multiplexed-address 8-bit bus, runs a
// single-byte cycle and returns read data with a timeout flag. Assumes each
// requester holds valid and fields stable until its done pulse.
module cam_bus_master
    import cam_bus_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int TIMEOUT_US = 1000,
    parameter int PHASE_CYC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            rq_valid,
    input  logic [1:0]            rq_write,
    input  logic [2*CAM_AW-1:0]   rq_addr,
    input  logic [2*CAM_DW-1:0]   rq_wdata,
    input  logic [1:0]            rq_target,
    output logic [1:0]            cp_done,
    output logic [CAM_DW-1:0]     cp_rdata,
    output logic                  cp_timeout,
    output logic [CAM_DW-1:0]     bus_dout,
    output logic                  bus_oe,
    input  logic [CAM_DW-1:0]     bus_din,
    output logic                  alo_stb,
    output logic                  ahi_stb,
    output logic [1:0]            cs_n,
    output logic                  rd_n,
    output logic                  wr_n,
    input  logic                  ack_n
);

    localparam int TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    cam_req_t   port_req [2];
    cam_req_t   sel_req;
    cam_req_t   req_q;
    cam_phase_e phase;
    logic       grant;
    logic       grant_idx;
    logic       owner_q;
    logic       timeout_q;
    logic       expired;

    // Pack each requester's fields into a request record.
    for (genvar i = 0; i < 2; i++) begin : g_port
        assign port_req[i] = '{
            write:  rq_write[i],
            addr:   rq_addr[i*CAM_AW +: CAM_AW],
            wdata:  rq_wdata[i*CAM_DW +: CAM_DW],
            target: rq_target[i]
        };
    end

    // Route the winning requester's record to the sequencer.
    always_comb begin
        sel_req = port_req[grant_idx];
    end

    cam_bus_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (rq_valid),
        .accept    (phase == PH_IDLE),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    cam_bus_ack_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (phase == PH_STROBE),
        .expired (expired)
    );

    cam_bus_sequencer #(
        .PHASE_CYC (PHASE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (grant),
        .start_req   (sel_req),
        .start_owner (grant_idx),
        .ack_n       (ack_n),
        .bus_din     (bus_din),
        .expired     (expired),
        .phase       (phase),
        .req_q       (req_q),
        .owner_q     (owner_q),
        .timeout_q   (timeout_q),
        .rdata_q     (cp_rdata)
    );

    cam_bus_pin_drive u_pins (
        .phase      (phase),
        .req_q      (req_q),
        .owner_q    (owner_q),
        .timeout_q  (timeout_q),
        .bus_dout   (bus_dout),
        .bus_oe     (bus_oe),
        .alo_stb    (alo_stb),
        .ahi_stb    (ahi_stb),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .cp_done    (cp_done),
        .cp_timeout (cp_timeout)
    );

endmodule

// File: rtl/cam_bus_master_chk.sv
// Module: protocol checker bound to the CAM bus master.
// Observes only top-level pins; all properties are disabled during reset.
module cam_bus_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cp_done,
    input logic       cp_timeout,
    input logic       bus_oe,
    input logic       alo_stb,
    input logic       ahi_stb,
    input logic [1:0] cs_n,
    input logic       rd_n,
    input logic       wr_n
);

    // R3: the two address latch strobes never overlap.
    a_r3_single_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !(alo_stb && ahi_stb));

    // R2: a latch strobe is only raised while the address byte is driven.
    a_r2_latch_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (alo_stb || ahi_stb) |-> bus_oe);

    // R5: at most one chip select is active.
    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n != 2'b00);

    // R5: a strobe falls only after a chip select was already active.
    a_r5_select_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> ($past(cs_n) != 2'b11));

    // R4: data lines are released while the read strobe is active.
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !bus_oe);

    // R5: read and write strobes are never active together.
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

    // R8: the done cycle has every control back to inactive.
    a_r8_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|cp_done) |-> (cs_n == 2'b11 && rd_n && wr_n && !bus_oe));

    // R6: done is a single-cycle pulse.
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|cp_done) |=> !(|cp_done));

    // R10: only one requester is told done at a time.
    a_r10_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cp_done));

    // R7: the timeout flag only appears with a done pulse.
    a_r7_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        cp_timeout |-> (|cp_done));

endmodule

bind cam_bus_master cam_bus_master_chk u_chk (.*);

// File: tb/cam_bus_master_test.sv
// Bench: behavioural cycle model compared with the pins on every falling edge.
module cam_bus_master_test;

    localparam int CLK_HZ = 125_000_000;
    localparam int TUS    = 1;
    localparam int P      = 2;
    localparam int TO     = (CLK_HZ / 1_000_000) * TUS;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        v0, v1, w0, w1, t0, t1;
    logic [15:0] a0, a1;
    logic [7:0]  d0, d1;
    logic [1:0]  cp_done;
    logic [7:0]  cp_rdata;
    logic        cp_timeout;
    logic [7:0]  bus_dout;
    logic        bus_oe;
    logic [7:0]  resp;
    logic        alo_stb, ahi_stb, rd_n, wr_n, ack_n;
    logic [1:0]  cs_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int ack_after;
    int scnt;
    int done_log[$];

    always #4 clk = ~clk;

    cam_bus_master #(
        .CLK_HZ (CLK_HZ), .TIMEOUT_US (TUS), .PHASE_CYC (P)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .rq_valid ({v1, v0}), .rq_write ({w1, w0}),
        .rq_addr ({a1, a0}), .rq_wdata ({d1, d0}), .rq_target ({t1, t0}),
        .cp_done (cp_done), .cp_rdata (cp_rdata), .cp_timeout (cp_timeout),
        .bus_dout (bus_dout), .bus_oe (bus_oe), .bus_din (resp),
        .alo_stb (alo_stb), .ahi_stb (ahi_stb), .cs_n (cs_n),
        .rd_n (rd_n), .wr_n (wr_n), .ack_n (ack_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Reference model state.
    int          m_busy, m_rel, m_own, m_t, m_w, m_last, m_to;
    logic [7:0]  m_rd, m_wd;
    logic [15:0] m_addr;
    logic        m_wr, m_tg;

    // Model advance on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rel = 0; m_last = 1; m_to = 0; m_rd = '0;
            m_own = 0; m_t = 0; m_w = 0;
        end else if (m_rel != 0) begin
            m_rel = 0; m_busy = 0;
        end else if (m_busy != 0) begin
            if (m_t < 6 * P) m_t++;
            else if (ack_n == 1'b0) begin m_rel = 1; m_to = 0; m_rd = resp; end
            else if (m_w == TO - 1) begin m_rel = 1; m_to = 1; m_rd = resp; end
            else m_w++;
        end else if (v0 || v1) begin
            if (v0 && v1) m_own = (m_last == 0) ? 1 : 0;
            else          m_own = v1 ? 1 : 0;
            m_last = m_own; m_busy = 1; m_t = 0; m_w = 0;
            if (m_own == 0) begin m_wr = w0; m_addr = a0; m_wd = d0; m_tg = t0; end
            else            begin m_wr = w1; m_addr = a1; m_wd = d1; m_tg = t1; end
        end
    end

    // Compare pins with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic       e_oe, e_alo, e_ahi, e_rd, e_wr;
            logic [1:0] e_cs, e_done;
            logic [7:0] e_dout;
            string      tag;
            e_oe = 0; e_alo = 0; e_ahi = 0; e_rd = 1; e_wr = 1;
            e_cs = 2'b11; e_done = 2'b00; e_dout = '0; tag = "R1";
            if (m_rel != 0) begin
                tag = "R8";
                e_done[m_own] = 1'b1;
                check(cp_timeout == m_to[0], m_to != 0 ? "R7" : "R6", "cp_timeout",
                      cp_timeout, m_to);
                check(cp_rdata == m_rd, m_to != 0 ? "R7" : "R6", "cp_rdata",
                      cp_rdata, m_rd);
            end else if (m_busy != 0) begin
                if (m_t < 2 * P)      tag = "R2";
                else if (m_t < 4 * P) tag = "R3";
                else if (m_t < 5 * P) tag = "R4";
                else                  tag = "R5";
                if ((m_own == 0 && v1) || (m_own == 1 && v0)) tag = "R10";
                if (m_t < 2 * P) begin
                    e_oe = 1; e_dout = m_addr[7:0]; e_alo = (m_t < P);
                end else if (m_t < 4 * P) begin
                    e_oe = 1; e_dout = m_addr[15:8]; e_ahi = (m_t < 3 * P);
                end else begin
                    e_oe = m_wr; e_dout = m_wd;
                    if (m_t >= 5 * P) e_cs[m_tg] = 1'b0;
                    if (m_t >= 6 * P) begin e_rd = m_wr; e_wr = ~m_wr; end
                end
            end
            check(bus_oe == e_oe, tag, "bus_oe", bus_oe, e_oe);
            if (e_oe) check(bus_dout == e_dout, tag, "bus_dout", bus_dout, e_dout);
            check(alo_stb == e_alo, tag, "alo_stb", alo_stb, e_alo);
            check(ahi_stb == e_ahi, tag, "ahi_stb", ahi_stb, e_ahi);
            check(cs_n == e_cs, tag, "cs_n", cs_n, e_cs);
            check(rd_n == e_rd, tag, "rd_n", rd_n, e_rd);
            check(wr_n == e_wr, tag, "wr_n", wr_n, e_wr);
            check(cp_done == e_done, (m_rel != 0) ? "R9" : tag, "cp_done", cp_done, e_done);
            if (cp_done[0]) begin done_log.push_back(0); v0 = 1'b0; end
            if (cp_done[1]) begin done_log.push_back(1); v1 = 1'b0; end
        end
    end

    // Target responder: acknowledge after ack_after strobe cycles (0 = never).
    always @(negedge clk) begin
        if (!rd_n || !wr_n) begin
            scnt++;
            ack_n = (ack_after > 0 && scnt >= ack_after) ? 1'b0 : 1'b1;
        end else begin
            scnt  = 0;
            ack_n = 1'b1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            summary();
        end
    end

    task automatic post(input int p, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, input bit tg);
        @(negedge clk);
        if (p == 0) begin w0 = wr; a0 = a; d0 = d; t0 = tg; v0 = 1'b1; end
        else        begin w1 = wr; a1 = a; d1 = d; t1 = tg; v1 = 1'b1; end
    endtask

    task automatic settle();
        while (v0 || v1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; v0 = 0; v1 = 0; w0 = 0; w1 = 0; t0 = 0; t1 = 0;
        a0 = '0; a1 = '0; d0 = '0; d1 = '0; resp = 8'h00; ack_after = 1;
        ack_n = 1'b1; scnt = 0;
        repeat (3) @(negedge clk);
        check(cs_n == 2'b11 && rd_n && wr_n, "R1", "reset controls",
              {cs_n, rd_n, wr_n}, 4'hF);
        check(!bus_oe && !alo_stb && !ahi_stb && cp_done == 2'b00, "R1",
              "reset drives", {bus_oe, alo_stb, ahi_stb, cp_done}, 0);
        rst_n = 1'b1;

        // R9: simultaneous requests after reset, port 0 first.
        done_log.delete();
        resp = 8'hA7; ack_after = 2;
        @(negedge clk);
        w0 = 0; a0 = 16'h12A5; t0 = 0; v0 = 1;
        w1 = 1; a1 = 16'h3C01; d1 = 8'h96; t1 = 1; v1 = 1;
        settle();
        check(done_log.size() == 2 && done_log[0] == 0, "R9", "first served",
              done_log.size() > 0 ? done_log[0] : -1, 0);
        check(done_log.size() == 2 && done_log[1] == 1, "R9", "second served",
              done_log.size() > 1 ? done_log[1] : -1, 1);

        // R6: read with acknowledge after three strobe cycles.
        resp = 8'h5C; ack_after = 3;
        post(0, 0, 16'hBEEF, 8'h00, 1); settle();
        // R5: write to target 1 with immediate acknowledge.
        resp = 8'h11; ack_after = 1;
        post(1, 1, 16'h0F80, 8'h3D, 1); settle();
        // R7: no acknowledge, read runs to timeout.
        resp = 8'hE2; ack_after = 0;
        post(0, 0, 16'h7001, 8'h00, 0); settle();
        // R7: acknowledge on the final timeout edge wins.
        resp = 8'h4B; ack_after = TO;
        post(1, 0, 16'h0203, 8'h00, 0); settle();
        // R7: acknowledge one cycle late is a timeout.
        resp = 8'h4C; ack_after = TO + 1;
        post(1, 1, 16'h0405, 8'hC3, 1); settle();

        // R10: port 1 owns the bus while port 0 requests mid-cycle.
        done_log.delete();
        resp = 8'h69; ack_after = 4;
        post(1, 1, 16'hA55A, 8'hF0, 0);
        repeat (5) @(negedge clk);
        w0 = 0; a0 = 16'h1234; t0 = 1; v0 = 1;
        settle();
        check(done_log.size() == 2 && done_log[0] == 1, "R10", "owner finishes first",
              done_log.size() > 0 ? done_log[0] : -1, 1);

        // R9: both again; port 0 was granted last so port 1 wins.
        done_log.delete();
        resp = 8'h0D; ack_after = 1;
        @(negedge clk);
        w0 = 1; a0 = 16'hFFFF; d0 = 8'h81; t0 = 0; v0 = 1;
        w1 = 0; a1 = 16'h0000; t1 = 1; v1 = 1;
        settle();
        check(done_log.size() == 2 && done_log[0] == 1, "R9", "alternate winner",
              done_log.size() > 0 ? done_log[0] : -1, 1);

        // R8: back-to-back from one requester.
        resp = 8'h22; ack_after = 2;
        post(0, 1, 16'h5500, 8'h55, 0);
        while (v0) @(negedge clk);
        post(0, 0, 16'h0055, 8'h00, 0); settle();

        repeat (4) @(negedge clk);
        summary();
    end

endmodule